// File: doc/BRIEF.md
# Smart Card Bit-Time Generator

This block sets the bit timing of a half-duplex smart card link. One elementary time unit (ETU), the length of one bit on the card line, lasts F/D periods of the card clock. Here that count is the product of two programmable divisors. A clock-to-baud ratio (8 bits) drives a prescaler. The prescaler in turn steps a baud counter that counts a 16-bit baud latch, which is held as a low byte and a high byte. The card clock is one of several source frequencies. Each source reaches the block as a one-cycle enable strobe in the system clock domain, and a two-bit select register picks the active source.

The outputs are a one-clock ETU tick at the end of every bit time, a one-clock sample strobe near the middle of each bit for the receiver, and the programmed guard-time count in ETUs. A character framer uses this count to add stop time. Registers are written through a byte-wide write-only port. After reset the divisors give 31 × 12 = 372 card clocks per ETU, which is the default F = 372, D = 1. The guard time resets to one ETU and the source select resets to 1.

Top module: `etu_timing_gen`

## Requirements
- R1: After reset `etuTick` and `sampleStrobe` are 0, `guardEtus` is 01h and `cardClkSel` is 1. The divisors reset to ratio 0Ch, latch low 1Fh and latch high 00h, so the ETU lasts 372 enables of source 1.
- R2: With latch value L = {high byte, low byte} and ratio R, successive ETU ticks are L × R enables of the selected source apart.
- R3: A divisor register that holds zero acts as 1. Ratio 0 with latch 0 gives an ETU of one enable.
- R4: A write to address 0 (ratio), 1 (latch low) or 2 (latch high) clears both counters at the write edge. With an enable on every cycle, the first ETU tick after the write is seen L × R cycles after the write edge, whatever phase the counters had before.
- R5: Exactly one sample strobe fires per ETU. It is seen (L>>1) × R + 1 enables after the ETU tick that opens the bit.
- R6: The ETU tick is a single-cycle pulse when L × R ≥ 2. It is registered and is seen one cycle after the enable that completes the bit.
- R7: The register at address 4, bits [1:0], selects which `srcTick` bit acts as the card clock enable (value k picks `srcTick[k]`). Writing it does not disturb the ETU phase.
- R8: Address 3 holds the guard-time count, which appears on `guardEtus`. Writing it does not disturb the ETU phase.
- R9: Writes to addresses 5 to 7 change no register and do not disturb the ETU phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 8 | Register write data |
| srcTick | input | 4 | One enable strobe per card clock source |
| etuTick | output | 1 | One-cycle pulse at the end of each ETU |
| sampleStrobe | output | 1 | One-cycle mid-bit sample pulse |
| guardEtus | output | 8 | Guard time in ETUs |
| cardClkSel | output | 2 | Selected card clock source |

## Verification
A corrupted prescaler or baud counter shows up at the ports within one ETU. The spacing between ETU ticks, or the gap from a tick to the next sample strobe, moves away from L × R or (L>>1) × R + 1. A counter that escapes its range can also stall the ticks completely. A missed resynchronisation shows in the first tick after a divisor write, which arrives at the old phase instead of exactly L × R cycles later. A write decoded to the wrong register shows at once on `guardEtus` or `cardClkSel`, or within one ETU as a shifted tick.

// File: rtl/etu_pkg.sv
package etu_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic resync;   // divisor write: clear both counters
    logic cardEn;   // one card clock period elapsed
  } etuStrobes_t;

  // Register addresses
  localparam int unsigned REG_RATIO    = 0;
  localparam int unsigned REG_LATCH_LO = 1;
  localparam int unsigned REG_LATCH_HI = 2;
  localparam int unsigned REG_GUARD    = 3;
  localparam int unsigned REG_SEL      = 4;

  // Reset values: 31 x 12 = 372 card clocks, one guard ETU, source 1
  localparam int unsigned DEF_RATIO    = 12;
  localparam int unsigned DEF_LATCH_LO = 31;
  localparam int unsigned DEF_LATCH_HI = 0;
  localparam int unsigned DEF_GUARD    = 1;
  localparam int unsigned DEF_SEL      = 1;

endpackage

// File: rtl/etu_ctrl.sv
module etu_ctrl
  import etu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 3,
  parameter int NUM_SRC = 4,
  localparam int SEL_W   = $clog2(NUM_SRC),
  localparam int LATCH_W = 2 * DATA_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] srcTick,
  output etuStrobes_t        strobes,
  output logic [LATCH_W-1:0] latchEff,
  output logic [DATA_W-1:0]  ratioEff,
  output logic [DATA_W-1:0]  guardEtus,
  output logic [SEL_W-1:0]   clkSel
);

  logic [DATA_W-1:0] ratioReg, latchLoReg, latchHiReg, guardReg;
  logic [SEL_W-1:0]  selReg;
  logic hitRatio, hitLo, hitHi, hitGuard, hitSel;
  logic [NUM_SRC-1:0] srcHit;

  assign hitRatio = wrEn && (wrAddr == ADDR_W'(REG_RATIO));
  assign hitLo    = wrEn && (wrAddr == ADDR_W'(REG_LATCH_LO));
  assign hitHi    = wrEn && (wrAddr == ADDR_W'(REG_LATCH_HI));
  assign hitGuard = wrEn && (wrAddr == ADDR_W'(REG_GUARD));
  assign hitSel   = wrEn && (wrAddr == ADDR_W'(REG_SEL));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ratioReg   <= DATA_W'(DEF_RATIO);
      latchLoReg <= DATA_W'(DEF_LATCH_LO);
      latchHiReg <= DATA_W'(DEF_LATCH_HI);
      guardReg   <= DATA_W'(DEF_GUARD);
      selReg     <= SEL_W'(DEF_SEL);
    end else begin
      if (hitRatio) ratioReg   <= wrData;
      if (hitLo)    latchLoReg <= wrData;
      if (hitHi)    latchHiReg <= wrData;
      if (hitGuard) guardReg   <= wrData;
      if (hitSel)   selReg     <= wrData[SEL_W-1:0];
    end
  end

  // Source select: one gated lane per card clock source
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign srcHit[i] = srcTick[i] && (selReg == SEL_W'(i));
  end

  // A zero divisor counts as one
  assign ratioEff = (ratioReg == '0) ? DATA_W'(1) : ratioReg;
  assign latchEff = ({latchHiReg, latchLoReg} == '0) ? LATCH_W'(1)
                                                     : {latchHiReg, latchLoReg};

  assign strobes.resync = hitRatio || hitLo || hitHi;
  assign strobes.cardEn = |srcHit;
  assign guardEtus      = guardReg;
  assign clkSel         = selReg;

  // R8: guard write lands on the output next cycle
  p_guard_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_W'(REG_GUARD)) |=> (guardEtus == $past(wrData)));

  // R7: select write lands on the output next cycle
  p_sel_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_W'(REG_SEL)) |=> (clkSel == $past(wrData[SEL_W-1:0])));

  // R9: unmapped addresses leave every register alone
  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr > ADDR_W'(REG_SEL)) |=>
      ($stable(latchEff) && $stable(ratioEff) && $stable(guardEtus) && $stable(clkSel)));

endmodule

// File: rtl/etu_datapath.sv
module etu_datapath
  import etu_pkg::*;
#(
  parameter int DATA_W  = 8,
  localparam int LATCH_W = 2 * DATA_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  etuStrobes_t        strobes,
  input  logic [LATCH_W-1:0] latchEff,
  input  logic [DATA_W-1:0]  ratioEff,
  output logic               etuTick,
  output logic               sampleStrobe
);

  logic [DATA_W-1:0]  preCnt;
  logic [LATCH_W-1:0] baudCnt;
  logic [LATCH_W-1:0] halfIdx;
  logic preLast, baudLast, preWrap;

  assign halfIdx  = latchEff >> 1;
  assign preLast  = (preCnt == ratioEff - 1'b1);
  assign baudLast = (baudCnt == latchEff - 1'b1);
  assign preWrap  = strobes.cardEn && preLast;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt       <= '0;
      baudCnt      <= '0;
      etuTick      <= 1'b0;
      sampleStrobe <= 1'b0;
    end else if (strobes.resync) begin
      preCnt       <= '0;
      baudCnt      <= '0;
      etuTick      <= 1'b0;
      sampleStrobe <= 1'b0;
    end else begin
      etuTick      <= preWrap && baudLast;
      sampleStrobe <= strobes.cardEn && (preCnt == '0) && (baudCnt == halfIdx);
      if (strobes.cardEn) begin
        if (preLast) begin
          preCnt  <= '0;
          baudCnt <= baudLast ? '0 : baudCnt + 1'b1;
        end else begin
          preCnt  <= preCnt + 1'b1;
        end
      end
    end
  end

  // R3: the control never hands over a zero divisor
  p_nonzero_div_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ratioEff != '0) && (latchEff != '0));

  // R2: both counters stay below their divisors
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (preCnt < ratioEff) && (baudCnt < latchEff));

  // R4: a divisor write clears the counters and the outputs
  p_resync_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.resync |=> (preCnt == '0 && baudCnt == '0 && !etuTick && !sampleStrobe));

  // R6: a tick always follows a card clock enable
  p_tick_en_r6: assert property (@(posedge clk) disable iff (!rstN)
    etuTick |-> $past(strobes.cardEn));

  // R5: the sample strobe follows an enable at prescaler count zero
  p_sample_pos_r5: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |-> ($past(strobes.cardEn) && $past(preCnt) == '0));

endmodule

// File: rtl/etu_timing_gen.sv
module etu_timing_gen
  import etu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 3,
  parameter int NUM_SRC = 4,
  localparam int SEL_W   = $clog2(NUM_SRC),
  localparam int LATCH_W = 2 * DATA_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] srcTick,
  output logic               etuTick,
  output logic               sampleStrobe,
  output logic [DATA_W-1:0]  guardEtus,
  output logic [SEL_W-1:0]   cardClkSel
);

  etuStrobes_t        strobes;
  logic [LATCH_W-1:0] latchEff;
  logic [DATA_W-1:0]  ratioEff;

  etu_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .srcTick   (srcTick),
    .strobes   (strobes),
    .latchEff  (latchEff),
    .ratioEff  (ratioEff),
    .guardEtus (guardEtus),
    .clkSel    (cardClkSel)
  );

  etu_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .latchEff     (latchEff),
    .ratioEff     (ratioEff),
    .etuTick      (etuTick),
    .sampleStrobe (sampleStrobe)
  );

endmodule

// File: tb/sim_etu_timing_gen.sv
module sim_etu_timing_gen;

  localparam int CLK_PERIOD = 10;
  localparam int WAIT_LIMIT = 20000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [3:0] srcTick = '0;
  logic       etuTick, sampleStrobe;
  logic [7:0] guardEtus;
  logic [1:0] cardClkSel;

  int cyc = 0;
  int etuCount = 0, sampCount = 0;
  int lastEtu = 0, lastSamp = 0;
  int nTests = 0, nFail = 0;
  bit finished = 1'b0;

  etu_timing_gen u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .srcTick(srcTick), .etuTick(etuTick), .sampleStrobe(sampleStrobe),
    .guardEtus(guardEtus), .cardClkSel(cardClkSel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // Source k pulses once every k+1 cycles
  always @(negedge clk) begin
    for (int k = 0; k < 4; k++) srcTick[k] <= ((cyc % (k + 1)) == 0);
    if (etuTick)      begin etuCount++;  lastEtu  = cyc; end
    if (sampleStrobe) begin sampCount++; lastSamp = cyc; end
  end

  function automatic int etuLen(int lat, int rat, int sel);
    int l = (lat == 0) ? 1 : lat;
    int r = (rat == 0) ? 1 : rat;
    return l * r * (sel + 1);
  endfunction

  function automatic int sampGap(int lat, int rat);
    int l = (lat == 0) ? 1 : lat;
    int r = (rat == 0) ? 1 : rat;
    return (l >> 1) * r + 1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wrReg(input int a, input int d, output int wc);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'(a); wrData = 8'(d);
    @(posedge clk); #1;
    wc = cyc;
    @(negedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic waitEtu(output int when);
    int start = etuCount;
    when = -1;
    for (int i = 0; i < WAIT_LIMIT; i++) begin
      @(negedge clk); #1;
      if (etuCount != start) begin when = lastEtu; return; end
    end
  endtask

  task automatic waitSamp(output int when);
    int start = sampCount;
    when = -1;
    for (int i = 0; i < WAIT_LIMIT; i++) begin
      @(negedge clk); #1;
      if (sampCount != start) begin when = lastSamp; return; end
    end
  endtask

  task automatic measure(output int intv);
    int a, b;
    waitEtu(a);
    waitEtu(b);
    intv = b - a;
  endtask

  task automatic setDiv(input int lat, input int rat, output int wc);
    int t;
    wrReg(0, rat, t);
    wrReg(2, lat >> 8, t);
    wrReg(1, lat & 8'hFF, wc);
  endtask

  initial begin
    repeat (CLK_PERIOD * 0 + 190000) @(posedge clk);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    int seedDummy, w, e, e2, s, iv, c0;
    seedDummy = $urandom(32'h00C0FFEE);

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    // R1: reset state
    check("R1 etuTick", int'(etuTick), 0);
    check("R1 sampleStrobe", int'(sampleStrobe), 0);
    check("R1 guardEtus", int'(guardEtus), 1);
    check("R1 cardClkSel", int'(cardClkSel), 1);
    measure(iv);
    check("R1 default ETU on source 1", iv, 744);

    // R7: switch to source 0
    wrReg(4, 0, w);
    check("R7 select readout", int'(cardClkSel), 0);
    measure(iv);
    check("R7 ETU on source 0", iv, 372);

    // R5: sample position and count per ETU
    waitEtu(e); c0 = sampCount;
    waitSamp(s);
    check("R5 sample gap default", s - e, sampGap(31, 12));
    // R6: one-cycle tick
    waitEtu(e2);
    check("R5 one sample per ETU", sampCount - c0, 1);
    @(negedge clk); #1;
    check("R6 tick width", int'(etuTick), 0);

    // R2: high byte counts
    setDiv(258, 3, w);
    waitEtu(e);
    check("R4 first tick after write", e - w, 774);
    measure(iv);
    check("R2 latch 0102h ratio 3", iv, 774);

    // R4: resync mid-ETU
    waitEtu(e);
    repeat (100) @(negedge clk);
    wrReg(1, 2, w);
    waitEtu(e2);
    check("R4 resync mid ETU", e2 - w, 774);

    // R3: zero divisors
    setDiv(0, 0, w);
    measure(iv);
    check("R3 both zero", iv, 1);
    wrReg(0, 5, w);
    measure(iv);
    check("R3 latch zero ratio 5", iv, 5);
    setDiv(7, 0, w);
    measure(iv);
    check("R3 ratio zero latch 7", iv, 7);

    // R8: guard write keeps phase
    setDiv(50, 2, w);
    waitEtu(e);
    repeat (20) @(negedge clk);
    wrReg(3, 7, w);
    waitEtu(e2);
    check("R8 phase after guard write", e2 - e, 100);
    check("R8 guardEtus", int'(guardEtus), 7);

    // R7: select write keeps phase
    waitEtu(e);
    repeat (20) @(negedge clk);
    wrReg(4, 0, w);
    waitEtu(e2);
    check("R7 phase after select write", e2 - e, 100);

    // R9: unmapped addresses
    waitEtu(e);
    repeat (20) @(negedge clk);
    wrReg(5, 0, w);
    wrReg(6, 0, w);
    wrReg(7, 8'hFF, w);
    waitEtu(e2);
    check("R9 phase after unmapped write", e2 - e, 100);
    check("R9 guard kept", int'(guardEtus), 7);
    check("R9 select kept", int'(cardClkSel), 0);

    // R2/R7/R5: random settings
    for (int it = 0; it < 12; it++) begin
      int lo, rt, sl;
      lo = $urandom_range(1, 40);
      rt = $urandom_range(1, 16);
      sl = $urandom_range(0, 3);
      setDiv(lo, rt, w);
      wrReg(4, sl, w);
      measure(iv);
      check("R2 R7 random ETU", iv, etuLen(lo, rt, sl));
      if (sl == 0) begin
        waitEtu(e);
        waitSamp(s);
        check("R5 random sample gap", s - e, sampGap(lo, rt));
      end
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule